// File: doc/BRIEF.md
# Board Interrupt Aggregator Register File

This block sits on a simple 32-bit register bus and serves two purposes. It holds a small set of general-purpose board registers: two LED data words, an LED control word, a switch word, three miscellaneous write words, a miscellaneous read word and two card-slot words. It also merges sixteen external interrupt request lines into a single upstream interrupt. Which lines may reach the upstream output is set by an enable mask register. The pending register records the most recent enabled line that changed, as a one-hot code. It is not a sticky accumulator.

Each cycle the block compares every input line with a per-line record of its last sampled level. A line whose level changed and whose enable bit is set overwrites the pending register with its own one-hot code. The upstream output then copies that line's new level, so it can fall as well as rise. The block decodes a 1 MiB window. The register offset is the bus address minus the window base. Reads are registered.

Top module: `board_irq_regfile`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, and `irq_out` and `bus_rdata` are 0.
- R2: The general registers store all 32 written bits. The window offsets are: LED data A 0x10, LED data B 0x14, LED control 0x40, switch 0x60, miscellaneous write 0x80/0x84/0x88, miscellaneous read 0x90, card slot 0xE0/0xE4. A write takes effect on the edge where `bus_we` is high. `bus_rdata` shows the addressed register one clock after the address is presented.
- R3: Writes to the enable mask (offset 0xC0) and the pending register (offset 0xD0) are ANDed with 0x000FEEFF before they are stored.
- R4: When line i differs from its recorded level and mask bit i is set, the pending register becomes exactly bit i set and `irq_out` takes line i's new level. Both are visible after the edge that samples the change.
- R5: A change on a line whose mask bit is clear updates only that line's level record. The pending register and `irq_out` keep their values, and enabling the line later does not replay the old change.
- R6: If several enabled lines change in the same cycle, the lowest-numbered one sets the pending code and `irq_out`.
- R7: A write to an in-window offset that is not a listed register changes nothing, and a read of such an offset returns zero.
- R8: An address below the base or at or above base + 0x100000 matches no register. Offsets are compared in full, so there is no aliasing.
- R9: When an enabled input change and a bus write to the pending register fall in the same cycle, the input-driven value wins. The input change is judged against the mask value held before any same-cycle mask write.
- R10: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address on the register bus |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | External interrupt request lines |
| irq_out | output | 1 | Upstream interrupt |

## Verification
Every result appears one clock after its cause. A write, or an input change sampled at a rising edge, is visible in the registers and on `irq_out` just after that edge. Read data appears one clock after the address. The bench changes inputs on the falling edge and samples on the next falling edge, half a period after the only edge involved. It reads a register through a second bus cycle, which samples only after the update has settled. The per-line sweep computes the expected pending code and output level from the 0x000FEEFF keep pattern, so lines whose mask bit can never be set are checked for silence.

// File: rtl/birq_pkg.sv
package birq_pkg;

    localparam int NUM_REGS = 12;

    typedef enum logic [3:0] {
        RI_LED_A    = 4'd0,
        RI_LED_B    = 4'd1,
        RI_LED_CTL  = 4'd2,
        RI_SWITCH   = 4'd3,
        RI_MISC_W1  = 4'd4,
        RI_MISC_W2  = 4'd5,
        RI_MISC_W3  = 4'd6,
        RI_MISC_RD  = 4'd7,
        RI_IRQ_MASK = 4'd8,
        RI_IRQ_PEND = 4'd9,
        RI_SLOT0    = 4'd10,
        RI_SLOT1    = 4'd11
    } reg_idx_e;

    // Byte offset of each register inside the window.
    function automatic logic [7:0] reg_offset(input int idx);
        logic [7:0] off;
        case (idx)
            0:       off = 8'h10;
            1:       off = 8'h14;
            2:       off = 8'h40;
            3:       off = 8'h60;
            4:       off = 8'h80;
            5:       off = 8'h84;
            6:       off = 8'h88;
            7:       off = 8'h90;
            8:       off = 8'hC0;
            9:       off = 8'hD0;
            10:      off = 8'hE0;
            default: off = 8'hE4;
        endcase
        return off;
    endfunction

    // Registers whose written value passes through the keep filter.
    function automatic bit is_filtered(input int idx);
        return (idx == int'(RI_IRQ_MASK)) || (idx == int'(RI_IRQ_PEND));
    endfunction

endpackage

// File: rtl/birq_decode.sv
module birq_decode
    import birq_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          SPAN_W = 20,
    parameter logic [31:0] BASE   = 32'h0800_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] match,
    output logic                hit
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(64'd1 << SPAN_W);

    logic [ADDR_W-1:0] off;
    logic              in_win;

    always_comb begin
        off    = addr - ADDR_W'(BASE);
        in_win = (off < SPAN);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign match[g] = in_win && (off == ADDR_W'(reg_offset(g)));
    end

    assign hit = |match;

endmodule

// File: rtl/birq_select.sv
module birq_select #(
    parameter int N = 16
) (
    input  logic [N-1:0] chg,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] lvl,
    output logic         fire,
    output logic [N-1:0] onehot,
    output logic         win_lvl
);
    // Scan from the top down so the lowest enabled change is the last one written.
    always_comb begin
        fire    = 1'b0;
        onehot  = '0;
        win_lvl = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (chg[i] && mask[i]) begin
                fire      = 1'b1;
                onehot    = '0;
                onehot[i] = 1'b1;
                win_lvl   = lvl[i];
            end
        end
    end

endmodule

// File: rtl/board_irq_regfile.sv
module board_irq_regfile
    import birq_pkg::*;
#(
    parameter int          NUM_IRQ = 16,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 32,
    parameter int          SPAN_W  = 20,
    parameter logic [31:0] BASE    = 32'h0800_0000,
    parameter logic [31:0] KEEP    = 32'h000F_EEFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic              irq_out
);
    localparam int MASK_I = int'(RI_IRQ_MASK);
    localparam int PEND_I = int'(RI_IRQ_PEND);
    localparam logic [DATA_W-1:0] KEEP_W = DATA_W'(KEEP);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [NUM_IRQ-1:0]              lvl;
        logic                            irq;
        logic [DATA_W-1:0]               rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_REGS-1:0] sel;
    logic                sel_hit;
    logic [NUM_IRQ-1:0]  chg;
    logic [NUM_IRQ-1:0]  cur_mask;
    logic                fire;
    logic [NUM_IRQ-1:0]  win_onehot;
    logic                win_lvl;

    birq_decode #(
        .ADDR_W(ADDR_W),
        .SPAN_W(SPAN_W),
        .BASE  (BASE)
    ) u_dec (
        .addr (bus_addr),
        .match(sel),
        .hit  (sel_hit)
    );

    assign chg      = irq_in ^ st_q.lvl;
    assign cur_mask = st_q.regs[MASK_I][NUM_IRQ-1:0];

    birq_select #(.N(NUM_IRQ)) u_sel (
        .chg    (chg),
        .mask   (cur_mask),
        .lvl    (irq_in),
        .fire   (fire),
        .onehot (win_onehot),
        .win_lvl(win_lvl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lvl = irq_in;

        // Registered read of the pre-write contents.
        st_d.rdata = '0;
        for (int g = 0; g < NUM_REGS; g++) begin
            if (sel[g]) begin
                st_d.rdata = st_q.regs[g];
            end
        end

        if (bus_we) begin
            for (int g = 0; g < NUM_REGS; g++) begin
                if (sel[g]) begin
                    st_d.regs[g] = is_filtered(g) ? (bus_wdata & KEEP_W) : bus_wdata;
                end
            end
        end

        // The input-driven update comes last so it overrides a same-cycle write.
        if (fire) begin
            st_d.regs[PEND_I] = DATA_W'(win_onehot);
            st_d.irq          = win_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq_out   = st_q.irq;

    AST_MASK_FILTERED: assert property (@(posedge clk) disable iff (rst)
        (st_q.regs[MASK_I] & ~KEEP_W) == '0); // R3

    AST_PEND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        fire |=> $onehot(st_q.regs[PEND_I])); // R4

    AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(irq_out)); // R5

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        fire |-> ((win_onehot - 1'b1) & chg & cur_mask) == '0); // R6

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !sel_hit |=> bus_rdata == '0); // R7

endmodule

// File: tb/board_irq_regfile_test.sv
`timescale 1ns/1ps
module board_irq_regfile_test;
    localparam logic [31:0] BASE = 32'h0800_0000;
    localparam logic [31:0] KEEP = 32'h000F_EEFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        irq_out;

    int nchk  = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    board_irq_regfile uut (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [7:0] offs(input int g);
        case (g)
            0: return 8'h10;  1: return 8'h14;  2: return 8'h40;  3: return 8'h60;
            4: return 8'h80;  5: return 8'h84;  6: return 8'h88;  7: return 8'h90;
            8: return 8'hC0;  9: return 8'hD0;  10: return 8'hE0; default: return 8'hE4;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic drive(input logic [15:0] v);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq_out", {31'd0, irq_out}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        for (int g = 0; g < 12; g++) begin
            rd(BASE + offs(g), v);
            check($sformatf("R1 reg %0d", g), v, 32'd0);
        end

        // R2: general registers keep all bits
        for (int g = 0; g < 12; g++) begin
            if (g != 8 && g != 9) wr(BASE + offs(g), 32'hF00D_0000 ^ (32'h1111_1111 * (g + 1)));
        end
        for (int g = 0; g < 12; g++) begin
            if (g != 8 && g != 9) begin
                rd(BASE + offs(g), v);
                check($sformatf("R2 reg %0d", g), v, 32'hF00D_0000 ^ (32'h1111_1111 * (g + 1)));
            end
        end

        // R10: read during write returns old value
        bus_addr = BASE + 32'h10; bus_we = 1'b1; bus_wdata = 32'h1234_5678;
        @(negedge clk);
        bus_we = 1'b0;
        check("R10 old value", bus_rdata, 32'hF00D_0000 ^ 32'h1111_1111);
        rd(BASE + 32'h10, v);
        check("R10 new value", v, 32'h1234_5678);

        // R3: filtered registers
        wr(BASE + 32'hC0, 32'hFFFF_FFFF);
        rd(BASE + 32'hC0, v);
        check("R3 mask", v, KEEP);
        wr(BASE + 32'hD0, 32'hFFFF_FFFF);
        rd(BASE + 32'hD0, v);
        check("R3 pend", v, KEEP);

        // R4: sweep every line rise and fall with all keepable bits enabled
        for (int i = 0; i < 16; i++) begin
            wr(BASE + 32'hD0, 32'd0);
            drive(16'd1 << i);
            check($sformatf("R4 rise irq line %0d", i), {31'd0, irq_out}, {31'd0, KEEP[i]});
            rd(BASE + 32'hD0, v);
            check($sformatf("R4 rise pend line %0d", i), v, KEEP[i] ? (32'd1 << i) : 32'd0);
            drive(16'd0);
            check($sformatf("R4 fall irq line %0d", i), {31'd0, irq_out}, 32'd0);
            rd(BASE + 32'hD0, v);
            check($sformatf("R4 fall pend line %0d", i), v, KEEP[i] ? (32'd1 << i) : 32'd0);
        end

        // R5: masked change is recorded silently
        wr(BASE + 32'hD0, 32'd0);
        wr(BASE + 32'hC0, 32'd0);
        drive(16'h0008);
        check("R5 masked irq", {31'd0, irq_out}, 32'd0);
        rd(BASE + 32'hD0, v);
        check("R5 masked pend", v, 32'd0);
        wr(BASE + 32'hC0, 32'h0000_0008);
        @(negedge clk);
        check("R5 no replay irq", {31'd0, irq_out}, 32'd0);
        rd(BASE + 32'hD0, v);
        check("R5 no replay pend", v, 32'd0);
        drive(16'h0000);
        rd(BASE + 32'hD0, v);
        check("R5 later change fires", v, 32'h0000_0008);

        // R6: simultaneous enabled changes, lowest wins
        wr(BASE + 32'hC0, 32'hFFFF_FFFF);
        wr(BASE + 32'hD0, 32'd0);
        drive(16'h0424);
        check("R6 irq", {31'd0, irq_out}, 32'd1);
        rd(BASE + 32'hD0, v);
        check("R6 pend lowest", v, 32'h0000_0004);
        drive(16'h0420);
        check("R6 fall irq", {31'd0, irq_out}, 32'd0);
        drive(16'h0000);
        rd(BASE + 32'hD0, v);
        check("R6 pair lowest", v, 32'h0000_0020);

        // R9: input update beats pend write; old mask applies
        bus_addr = BASE + 32'hD0; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFFF; irq_in = 16'h0002;
        @(negedge clk);
        bus_we = 1'b0;
        check("R9 irq", {31'd0, irq_out}, 32'd1);
        rd(BASE + 32'hD0, v);
        check("R9 pend input wins", v, 32'h0000_0002);
        bus_addr = BASE + 32'hC0; bus_we = 1'b1; bus_wdata = 32'd0; irq_in = 16'h0003;
        @(negedge clk);
        bus_we = 1'b0;
        rd(BASE + 32'hD0, v);
        check("R9 old mask used", v, 32'h0000_0001);
        rd(BASE + 32'hC0, v);
        check("R9 mask written", v, 32'd0);
        drive(16'h0000);

        // R7: unlisted offsets
        wr(BASE + 32'h44, 32'hDEAD_BEEF);
        rd(BASE + 32'h44, v);
        check("R7 unlisted read", v, 32'd0);
        rd(BASE + 32'h12, v);
        check("R7 misaligned read", v, 32'd0);
        rd(BASE + 32'h14, v);
        check("R7 neighbour intact", v, 32'hF00D_0000 ^ 32'h2222_2222);

        // R8: window limits and no aliasing
        wr(BASE + 32'h0010_0010, 32'hAAAA_5555);
        wr(BASE - 32'h10 + 32'h40 - 32'h30, 32'h5555_AAAA);
        wr(BASE + 32'h0000_1010, 32'h0BAD_0BAD);
        rd(BASE + 32'h10, v);
        check("R8 LED A untouched", v, 32'h1234_5678);
        rd(BASE + 32'h0010_0010, v);
        check("R8 above window", v, 32'd0);
        rd(BASE + 32'h0000_1010, v);
        check("R8 no alias", v, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule